// File: doc/BRIEF.md
# Pixel Row Select Sequencer

This block produces the timing waveform that selects one row of an image sensor's pixel array for readout. A line request carries the row to read. The block places that row on a shared 10-bit address bus and latches it with an active-low load strobe. It then runs the column-amplifier sample, reset and sample sequence. Every interval in the sequence is fixed and is set as a parameter in nanoseconds. The block turns each one into clock cycles, rounding up, for a system clock whose period is also a parameter (10 ns by default).

A request can carry a frame-start flag. On such a line an amplifier calibration pulse is placed a fixed delay after the first sample strobe rises. A request can also carry a second row for electronic shuttering. That row is loaded and reset once the read row has been sampled, which shortens its exposure. A one-cycle pulse marks the moment column readout may begin. If no shutter row is pending, the sequencer goes idle in that same cycle, so the next line can be set up while the previous row is still being clocked out.

Top module: `row_sel_seq`

## Requirements
- R1: After reset, the load strobe `row_ld_n` is high, `samp_s`, `samp_r`, `row_reset`, `amp_cal`, `col_start` and `busy` are low, and the bus reads 0.
- R2: A request (`line_req` high for one cycle while `busy` is low) is taken on the next edge, and `busy` rises on that edge. A request while `busy` is high has no effect: its row never reaches the bus and no extra load occurs.
- R3: The read row appears on `row_addr` exactly C_SU cycles before `row_ld_n` falls. `row_ld_n` stays low for C_LD cycles.
- R4: `samp_s` is high for C_B cycles. It falls exactly C_A cycles after `row_ld_n` falls.
- R5: `row_reset` rises C_C cycles after `samp_s` falls and stays high for C_D cycles.
- R6: `samp_r` is high for C_B cycles and falls exactly C_E cycles after `row_reset` falls. The bus holds the read row, unchanged, from the load until `samp_r` falls.
- R7: `col_start` is a single-cycle pulse that begins in the cycle `samp_r` falls. Without a shutter row, `busy` falls in that same cycle.
- R8: With the frame-start flag set, `amp_cal` rises C_H cycles after `samp_s` rises and lasts C_I cycles. Without the flag, `amp_cal` stays low for the whole line.
- R9: With a shutter row, the bus takes that row in the cycle `samp_r` falls. `row_ld_n` falls C_SU cycles later and is low for C_LD cycles. `row_reset` rises as the load ends and is high for C_D cycles. The bus is held C_G more cycles, after which `busy` falls.
- R10: At most one of `samp_s`, `samp_r` and `row_reset` is high in any cycle.
- R11: A new request given in the first cycle that `busy` is low is accepted.

Default cycle counts at 10 ns: C_SU=1, C_LD=2, C_A=360, C_B=40, C_C=5, C_D=20, C_E=160, C_G=10, C_H=15, C_I=50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_req | input | 1 | Start a line (taken when not busy) |
| line_row | input | 10 | Row to read |
| frame_first | input | 1 | First line of a frame: issue calibration |
| shut_en | input | 1 | Also reset a shutter row after sampling |
| shut_row | input | 10 | Row to reset for shuttering |
| busy | output | 1 | Sequence in progress |
| row_addr | output | 10 | Shared row address bus |
| row_ld_n | output | 1 | Active-low row address load strobe |
| samp_s | output | 1 | Signal-level sample strobe |
| samp_r | output | 1 | Reset-level sample strobe |
| row_reset | output | 1 | Row reset pulse |
| amp_cal | output | 1 | Output-amplifier calibration pulse |
| col_start | output | 1 | Column readout may begin |

## Verification
The bench times every edge in cycles and compares each interval with its exact count, not with a lower bound. A design off by one on any counter, for example one that measures the S-fall delay from the end of the load instead of its start, will miss by a few cycles and fail. Calibration is checked on lines with and without the flag. A sequencer that leaves the calibration armed across lines will pulse on the second line and fail. A request sent in the middle of a line must leave the bus untouched. A back-to-back request must be accepted in the very cycle `busy` falls. A design that needs an extra idle cycle there will leave `busy` low one cycle too long.

// File: rtl/row_sel_pkg.sv
package row_sel_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOAD,
    ST_HOLD,
    ST_SETTLE,
    ST_SAMP_S,
    ST_GAP,
    ST_RSTP,
    ST_WAIT_R,
    ST_SAMP_R,
    ST_SH_SETUP,
    ST_SH_LOAD,
    ST_SH_RST,
    ST_SH_HOLD
  } seq_state_t;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int ns2cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/row_sel_interval.sv
module row_sel_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/row_sel_cal_gen.sv
module row_sel_cal_gen #(
  parameter int DLY_CYC = 15,
  parameter int WID_CYC = 50,
  parameter int CNT_W   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic cal_o
);

  typedef enum logic [1:0] {CG_IDLE, CG_WAIT, CG_ON} cg_state_t;

  localparam logic [CNT_W-1:0] DLY_M1 = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] WID_M1 = CNT_W'(WID_CYC - 1);

  cg_state_t        ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= CG_IDLE;
      cnt   <= '0;
      cal_o <= 1'b0;
    end else begin
      case (ph)
        CG_IDLE: if (trig) begin
          ph  <= CG_WAIT;
          cnt <= DLY_M1;
        end
        CG_WAIT: if (cnt == 0) begin
          ph    <= CG_ON;
          cnt   <= WID_M1;
          cal_o <= 1'b1;
        end else cnt <= cnt - 1'b1;
        CG_ON: if (cnt == 0) begin
          ph    <= CG_IDLE;
          cal_o <= 1'b0;
        end else cnt <= cnt - 1'b1;
        default: ph <= CG_IDLE;
      endcase
    end
  end

  // R8: calibration is only raised by the delay phase that a trigger started
  a_r8_cal_from_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_o) |-> $past(ph) == CG_WAIT);

endmodule

// File: rtl/row_sel_seq.sv
module row_sel_seq #(
  parameter int ADDR_W      = 10,
  parameter int CNT_W       = 16,
  parameter int CLK_NS      = 10,
  parameter int T_SU_NS     = 10,
  parameter int T_LD_NS     = 20,
  parameter int T_HD_NS     = 10,
  parameter int T_SEL_NS    = 3600,
  parameter int T_SAMP_NS   = 400,
  parameter int T_GAP_NS    = 50,
  parameter int T_RST_NS    = 200,
  parameter int T_RFALL_NS  = 1600,
  parameter int T_RHOLD_NS  = 100,
  parameter int T_CALDLY_NS = 150,
  parameter int T_CALW_NS   = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_req,
  input  logic [ADDR_W-1:0] line_row,
  input  logic              frame_first,
  input  logic              shut_en,
  input  logic [ADDR_W-1:0] shut_row,
  output logic              busy,
  output logic [ADDR_W-1:0] row_addr,
  output logic              row_ld_n,
  output logic              samp_s,
  output logic              samp_r,
  output logic              row_reset,
  output logic              amp_cal,
  output logic              col_start
);
  import row_sel_pkg::*;

  localparam int C_SU  = ns2cyc(T_SU_NS, CLK_NS);
  localparam int C_LD  = ns2cyc(T_LD_NS, CLK_NS);
  localparam int C_HD  = ns2cyc(T_HD_NS, CLK_NS);
  localparam int C_A   = ns2cyc(T_SEL_NS, CLK_NS);
  localparam int C_B   = ns2cyc(T_SAMP_NS, CLK_NS);
  localparam int C_C   = ns2cyc(T_GAP_NS, CLK_NS);
  localparam int C_D   = ns2cyc(T_RST_NS, CLK_NS);
  localparam int C_E   = ns2cyc(T_RFALL_NS, CLK_NS);
  localparam int C_G   = ns2cyc(T_RHOLD_NS, CLK_NS);
  localparam int C_H   = ns2cyc(T_CALDLY_NS, CLK_NS);
  localparam int C_I   = ns2cyc(T_CALW_NS, CLK_NS);
  // Settle so that S falls C_A cycles after the load strobe falls.
  localparam int C_SET = (C_A - C_LD - C_HD - C_B < 1) ? 1 : (C_A - C_LD - C_HD - C_B);
  localparam int C_WR  = (C_E - C_B < 1) ? 1 : (C_E - C_B);

  seq_state_t       st, nxt;
  logic             zero, ld_cnt;
  logic [CNT_W-1:0] dur_m1;
  logic [ADDR_W-1:0] shut_q;
  logic             shut_q_en, cal_arm, cal_trig;

  function automatic logic [CNT_W-1:0] dur_of(input seq_state_t s);
    int d;
    case (s)
      ST_SETUP, ST_SH_SETUP: d = C_SU;
      ST_LOAD, ST_SH_LOAD:   d = C_LD;
      ST_HOLD:               d = C_HD;
      ST_SETTLE:             d = C_SET;
      ST_SAMP_S, ST_SAMP_R:  d = C_B;
      ST_GAP:                d = C_C;
      ST_RSTP, ST_SH_RST:    d = C_D;
      ST_WAIT_R:             d = C_WR;
      ST_SH_HOLD:            d = C_G;
      default:               d = 1;
    endcase
    return CNT_W'(d - 1);
  endfunction

  always_comb begin
    nxt = st;
    if (st == ST_IDLE) begin
      if (line_req) nxt = ST_SETUP;
    end else if (zero) begin
      case (st)
        ST_SETUP:    nxt = ST_LOAD;
        ST_LOAD:     nxt = ST_HOLD;
        ST_HOLD:     nxt = ST_SETTLE;
        ST_SETTLE:   nxt = ST_SAMP_S;
        ST_SAMP_S:   nxt = ST_GAP;
        ST_GAP:      nxt = ST_RSTP;
        ST_RSTP:     nxt = ST_WAIT_R;
        ST_WAIT_R:   nxt = ST_SAMP_R;
        ST_SAMP_R:   nxt = shut_q_en ? ST_SH_SETUP : ST_IDLE;
        ST_SH_SETUP: nxt = ST_SH_LOAD;
        ST_SH_LOAD:  nxt = ST_SH_RST;
        ST_SH_RST:   nxt = ST_SH_HOLD;
        ST_SH_HOLD:  nxt = ST_IDLE;
        default:     nxt = ST_IDLE;
      endcase
    end
  end

  assign ld_cnt   = (nxt != st);
  assign dur_m1   = dur_of(nxt);
  assign cal_trig = cal_arm && (nxt == ST_SAMP_S) && (st != ST_SAMP_S);

  row_sel_interval #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_cnt),
    .load_val (dur_m1),
    .zero     (zero)
  );

  row_sel_cal_gen #(.DLY_CYC(C_H), .WID_CYC(C_I), .CNT_W(CNT_W)) u_cal (
    .clk   (clk),
    .rst   (rst),
    .trig  (cal_trig),
    .cal_o (amp_cal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      row_addr  <= '0;
      row_ld_n  <= 1'b1;
      samp_s    <= 1'b0;
      samp_r    <= 1'b0;
      row_reset <= 1'b0;
      busy      <= 1'b0;
      col_start <= 1'b0;
      shut_q    <= '0;
      shut_q_en <= 1'b0;
      cal_arm   <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && line_req) begin
        row_addr  <= line_row;
        shut_q    <= shut_row;
        shut_q_en <= shut_en;
        cal_arm   <= frame_first;
      end
      if (cal_trig) cal_arm <= 1'b0;
      if (nxt == ST_SH_SETUP && st != ST_SH_SETUP) row_addr <= shut_q;
      row_ld_n  <= !(nxt == ST_LOAD || nxt == ST_SH_LOAD);
      samp_s    <= (nxt == ST_SAMP_S);
      samp_r    <= (nxt == ST_SAMP_R);
      row_reset <= (nxt == ST_RSTP || nxt == ST_SH_RST);
      busy      <= (nxt != ST_IDLE);
      col_start <= (st == ST_SAMP_R) && (nxt != ST_SAMP_R);
    end
  end

  // R10: sample and reset strobes never overlap
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({samp_s, samp_r, row_reset}) <= 1);
  // R2: the load strobe only goes low inside a line
  a_r2_load_in_line: assert property (@(posedge clk) disable iff (rst)
    !row_ld_n |-> busy);
  // R6: bus frozen from sampling through the reset-level sample
  a_r6_bus_frozen: assert property (@(posedge clk) disable iff (rst)
    (st inside {ST_SAMP_S, ST_GAP, ST_RSTP, ST_WAIT_R, ST_SAMP_R}) |-> $stable(row_addr));
  // R7: readout start is one cycle wide
  a_r7_go_single: assert property (@(posedge clk) disable iff (rst)
    col_start |=> !col_start);
  // R4: S only rises at the end of the settle interval
  a_r4_s_after_settle: assert property (@(posedge clk) disable iff (rst)
    $rose(samp_s) |-> $past(st) == ST_SETTLE);
  // R8: calibration lies inside a line
  a_r8_cal_in_line: assert property (@(posedge clk) disable iff (rst)
    amp_cal |-> busy);

endmodule

// File: tb/row_sel_seq_tb.sv
module row_sel_seq_tb;

  localparam int C_SU = 1, C_LD = 2, C_A = 360, C_B = 40, C_C = 5, C_D = 20;
  localparam int C_E = 160, C_G = 10, C_H = 15, C_I = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_req = 1'b0, frame_first = 1'b0, shut_en = 1'b0;
  logic [9:0] line_row = '0, shut_row = '0;
  logic busy, row_ld_n, samp_s, samp_r, row_reset, amp_cal, col_start;
  logic [9:0] row_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  row_sel_seq u_dut (
    .clk(clk), .rst(rst), .line_req(line_req), .line_row(line_row),
    .frame_first(frame_first), .shut_en(shut_en), .shut_row(shut_row),
    .busy(busy), .row_addr(row_addr), .row_ld_n(row_ld_n), .samp_s(samp_s),
    .samp_r(samp_r), .row_reset(row_reset), .amp_cal(amp_cal), .col_start(col_start)
  );

  // Edge recorder, sampled on the falling clock edge
  int cyc = 0;
  int ldf[4], ldr[4], rsr[4], rsf[4], bch[4];
  logic [9:0] ld_addr[4], bch_val[4];
  int n_ldf, n_ldr, n_rsr, n_rsf, n_bch, n_cal, n_go;
  int s_r, s_f, r_r, r_f, c_r, c_f, go_c, busy_f;
  bit seen_bad;
  logic [9:0] bad_row;
  logic p_ld = 1, p_s = 0, p_r = 0, p_rs = 0, p_cal = 0, p_busy = 0;
  logic [9:0] p_addr = '0;

  task automatic clear_rec();
    n_ldf = 0; n_ldr = 0; n_rsr = 0; n_rsf = 0; n_bch = 0; n_cal = 0; n_go = 0;
    s_r = -1; s_f = -1; r_r = -1; r_f = -1; c_r = -1; c_f = -1; go_c = -1; busy_f = -1;
    seen_bad = 0;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (p_ld && !row_ld_n && n_ldf < 4) begin ldf[n_ldf] = cyc; ld_addr[n_ldf] = row_addr; n_ldf++; end
      if (!p_ld && row_ld_n && n_ldr < 4) begin ldr[n_ldr] = cyc; n_ldr++; end
      if (!p_rs && row_reset && n_rsr < 4) begin rsr[n_rsr] = cyc; n_rsr++; end
      if (p_rs && !row_reset && n_rsf < 4) begin rsf[n_rsf] = cyc; n_rsf++; end
      if (row_addr != p_addr && n_bch < 4) begin bch[n_bch] = cyc; bch_val[n_bch] = row_addr; n_bch++; end
      if (!p_s && samp_s) s_r = cyc;
      if (p_s && !samp_s) s_f = cyc;
      if (!p_r && samp_r) r_r = cyc;
      if (p_r && !samp_r) r_f = cyc;
      if (!p_cal && amp_cal) begin c_r = cyc; n_cal++; end
      if (p_cal && !amp_cal) c_f = cyc;
      if (col_start) begin go_c = cyc; n_go++; end
      if (p_busy && !busy) busy_f = cyc;
      if (row_addr == bad_row) seen_bad = 1;
    end
    p_ld = row_ld_n; p_s = samp_s; p_r = samp_r; p_rs = row_reset;
    p_cal = amp_cal; p_busy = busy; p_addr = row_addr;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start_line(input logic [9:0] rd, input bit fr, input bit se, input logic [9:0] sr);
    @(negedge clk);
    line_row = rd; frame_first = fr; shut_en = se; shut_row = sr; line_req = 1'b1;
    @(negedge clk);
    line_req = 1'b0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
    if (k >= 3000) chk("R7", "timeout waiting idle", 1, 0);
  endtask

  task automatic check_read_part(input logic [9:0] rd, input bit fr);
    chk("R3", "bus setup", ldf[0] - bch[0], C_SU);
    chk("R3", "addr at load", int'(ld_addr[0]), int'(rd));
    chk("R3", "load width", ldr[0] - ldf[0], C_LD);
    chk("R4", "S fall after load", s_f - ldf[0], C_A);
    chk("R4", "S width", s_f - s_r, C_B);
    chk("R5", "reset after S", rsr[0] - s_f, C_C);
    chk("R5", "reset width", rsf[0] - rsr[0], C_D);
    chk("R6", "R fall after reset", r_f - rsf[0], C_E);
    chk("R6", "R width", r_f - r_r, C_B);
    chk("R6", "bus held to R fall", (n_bch < 2) || (bch[1] >= r_f), 1);
    chk("R7", "go at R fall", go_c, r_f);
    chk("R7", "go count", n_go, 1);
    if (fr) begin
      chk("R8", "cal delay", c_r - s_r, C_H);
      chk("R8", "cal width", c_f - c_r, C_I);
    end else chk("R8", "no cal", n_cal, 0);
  endtask

  task automatic t_reset_state();
    chk("R1", "ld_n", row_ld_n, 1);
    chk("R1", "strobes", {samp_s, samp_r, row_reset, amp_cal, col_start, busy}, 0);
    chk("R1", "bus", row_addr, 0);
  endtask

  task automatic t_plain(input logic [9:0] rd, input bit fr);
    clear_rec(); bad_row = 10'h3FF;
    start_line(rd, fr, 0, 0);
    chk("R2", "busy on accept", busy, 1);
    wait_idle(); repeat (5) @(negedge clk);
    check_read_part(rd, fr);
    chk("R7", "busy falls with R", busy_f, r_f);
  endtask

  task automatic t_shutter(input logic [9:0] rd, input logic [9:0] sr);
    clear_rec(); bad_row = 10'h3FF;
    start_line(rd, 1, 1, sr);
    wait_idle(); repeat (5) @(negedge clk);
    check_read_part(rd, 1);
    chk("R9", "shutter bus at R fall", bch[1], r_f);
    chk("R9", "shutter addr", int'(ld_addr[1]), int'(sr));
    chk("R9", "shutter setup", ldf[1] - bch[1], C_SU);
    chk("R9", "shutter load width", ldr[1] - ldf[1], C_LD);
    chk("R9", "reset at load end", rsr[1], ldr[1]);
    chk("R9", "shutter reset width", rsf[1] - rsr[1], C_D);
    chk("R9", "hold then idle", busy_f - rsf[1], C_G);
  endtask

  task automatic t_ignore_busy();
    clear_rec(); bad_row = 10'h2AA;
    start_line(10'h011, 0, 0, 0);
    repeat (50) @(negedge clk);
    line_row = 10'h2AA; line_req = 1'b1; @(negedge clk); line_req = 1'b0;
    wait_idle(); repeat (5) @(negedge clk);
    chk("R2", "ignored row never on bus", seen_bad, 0);
    chk("R2", "single load", n_ldf, 1);
    chk("R2", "idle after line", busy, 0);
  endtask

  task automatic t_back_to_back();
    int k;
    clear_rec(); bad_row = 10'h3FF;
    start_line(10'h0F0, 0, 0, 0);
    line_row = 10'h10F; line_req = 1'b1;
    k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
    @(negedge clk);
    line_req = 1'b0;
    chk("R11", "next accepted at once", busy, 1);
    chk("R11", "next row on bus", row_addr, 10'h10F);
    wait_idle();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_plain(10'h155, 0);
    t_plain(10'h0A3, 1);
    t_plain(10'h3FE, 0);
    t_shutter(10'h200, 10'h07C);
    t_ignore_busy();
    t_back_to_back();
    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule